// File: doc/BRIEF.md
# Byte-Wide Parallel Configuration Slave Port

This block is the device end of an 8-bit parallel configuration link. An external host supplies the configuration clock, an active-low select, a direction line (low writes into the device, high reads out of it) and an 8-bit data bus. In write direction the port takes one byte per rising clock edge and hands it to an internal byte sink with a one-cycle valid strobe. In read direction it pops bytes from an internal readback source and drives them onto the bus.

The bus pin numbering is the reverse of the byte bit numbering: pin 0 carries the byte's most significant bit. The first four pins therefore hold the upper nibble. Readback, and any port activity after configuration has finished, depends on a persist setting. A done input from the sink ends configuration mode. Turning the direction line to read while a configuration is under way is a protocol violation, and the port locks itself out until reset.

Top module: `cfg_par_port`

## Requirements
- R1: After reset `wr_valid_o`, `bus_oe_o`, `rb_pop_o`, `abort_o`, `underflow_o` and `user_mode_o` are all 0.
- R2: On an edge with `cs_ni` high, no input has any effect: no byte is written, none is popped, the bus is not driven and no error is flagged.
- R3: On an edge with `cs_ni` low and `rdwr_i` low in an active port, `wr_valid_o` is 1 for the following cycle and `wr_byte_o[7-k]` equals `bus_i[k]`. Pin 0 is the MSB.
- R4: On an edge with `cs_ni` low, `rdwr_i` high, `persist_i` 1 and a non-empty source, `rb_pop_o` is 1 during that cycle. After the edge `bus_oe_o` is 1 and `bus_o[k]` equals bit 7-k of the popped byte.
- R5: With `persist_i` 0, a read request pops nothing and leaves `bus_oe_o` at 0.
- R6: `bus_oe_o` is 1 only in the cycle after an edge that carried a read request allowed by R4/R5. It is never 1 after a write edge.
- R7: During configuration, once a write has been accepted, an edge with `cs_ni` low and `rdwr_i` high sets `abort_o`. That edge performs no read. From then until reset, `abort_o` stays 1 and no byte is written or read.
- R8: `done_i` high on an edge during configuration makes `user_mode_o` 1 from the next cycle.
- R9: In user mode with `persist_i` 0, both write and read requests are ignored.
- R10: In user mode with `persist_i` 1, writes and reads behave as in R3 and R4, and a read after a write is not an error.
- R11: A permitted read edge with an empty source pops nothing. It sets `underflow_o`, which then stays 1 until reset, keeps `bus_oe_o` at 1 and leaves `bus_o` at its previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock from the host |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Port select, active low |
| rdwr_i | input | 1 | Direction: 0 write into device, 1 read out |
| bus_i | input | 8 | Bus pins as seen from the pad, pin 0 = MSB |
| bus_o | output | 8 | Readback byte on the bus pins, pin 0 = MSB |
| bus_oe_o | output | 1 | Bus drive enable |
| persist_i | input | 1 | Keep port alive in user mode and permit readback |
| done_i | input | 1 | Configuration finished, from the sink |
| wr_byte_o | output | 8 | Captured byte to the sink |
| wr_valid_o | output | 1 | One-cycle strobe per captured byte |
| rb_data_i | input | 8 | Head byte of the readback source |
| rb_empty_i | input | 1 | Readback source is empty |
| rb_pop_o | output | 1 | Pop the readback source on this edge |
| abort_o | output | 1 | Sticky direction-change error |
| underflow_o | output | 1 | Sticky readback underflow |
| user_mode_o | output | 1 | Configuration has completed |

## Verification
Reaching the lockout needs a particular order of steps: a read before any write must pass without error, and the read that follows an accepted write must trip it. The stimulus does both in one configuration session and then offers another write, which the scoreboard must never see. Underflow is reached by draining a two-byte source and reading once more. After that the bus value is compared with the last popped byte, and the flag is checked again after later traffic to show that it sticks. The persist-off case in user mode runs in its own session that starts from reset.

// File: rtl/cfg_par_pkg.sv
package cfg_par_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_CFG   = 2'd0,
    MODE_USER  = 2'd1,
    MODE_ABORT = 2'd2
  } port_mode_e;
endpackage

// File: rtl/cfg_par_ctrl.sv
module cfg_par_ctrl
  import cfg_par_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rdwr_i,
  input  logic persist_i,
  input  logic done_i,
  output logic wr_req_o,
  output logic rd_req_o,
  output logic abort_o,
  output logic user_mode_o
);
  port_mode_e mode_q, mode_d;
  logic wr_seen_q;
  logic active, sel, dir_err;

  assign active  = (mode_q == MODE_CFG) || (mode_q == MODE_USER && persist_i);
  assign sel     = !cs_ni && active;
  // read after a write inside one configuration session
  assign dir_err = (mode_q == MODE_CFG) && wr_seen_q && !cs_ni && rdwr_i;

  assign wr_req_o = sel && !rdwr_i;
  assign rd_req_o = sel && rdwr_i && persist_i && !dir_err;

  always_comb begin
    mode_d = mode_q;
    if (dir_err)                              mode_d = MODE_ABORT;
    else if (mode_q == MODE_CFG && done_i)    mode_d = MODE_USER;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_CFG;
      wr_seen_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (mode_q == MODE_CFG && wr_req_o) wr_seen_q <= 1'b1;
    end
  end

  assign abort_o     = (mode_q == MODE_ABORT);
  assign user_mode_o = (mode_q == MODE_USER);

  assert_abort_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> abort_o);
  assert_user_needs_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(user_mode_o) |-> $past(done_i));
  assert_no_req_in_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !(wr_req_o || rd_req_o));
endmodule

// File: rtl/cfg_par_wr.sv
module cfg_par_wr #(
  parameter int unsigned W = cfg_par_pkg::BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] byte_o,
  output logic         valid_o
);
  logic [W-1:0] swapped;

  for (genvar k = 0; k < W; k++) begin : g_swap
    assign swapped[W-1-k] = pins_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= req_i;
      if (req_i) byte_o <= swapped;
    end
  end

  assert_valid_follows_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(req_i));
endmodule

// File: rtl/cfg_par_rd.sv
module cfg_par_rd #(
  parameter int unsigned W = cfg_par_pkg::BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic [W-1:0] src_data_i,
  input  logic         src_empty_i,
  output logic         pop_o,
  output logic [W-1:0] pins_o,
  output logic         oe_o,
  output logic         underflow_o
);
  logic [W-1:0] hold_q;

  assign pop_o = req_i && !src_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      oe_o        <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      oe_o <= req_i;
      if (pop_o)                      hold_q      <= src_data_i;
      if (req_i && src_empty_i)       underflow_o <= 1'b1;
    end
  end

  for (genvar k = 0; k < W; k++) begin : g_swap
    assign pins_o[k] = hold_q[W-1-k];
  end

  assert_underflow_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);
  assert_hold_on_empty_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && src_empty_i) |=> $stable(pins_o));
endmodule

// File: rtl/cfg_par_port.sv
module cfg_par_port
  import cfg_par_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_ni,
  input  logic         rdwr_i,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] bus_o,
  output logic         bus_oe_o,
  input  logic         persist_i,
  input  logic         done_i,
  output logic [W-1:0] wr_byte_o,
  output logic         wr_valid_o,
  input  logic [W-1:0] rb_data_i,
  input  logic         rb_empty_i,
  output logic         rb_pop_o,
  output logic         abort_o,
  output logic         underflow_o,
  output logic         user_mode_o
);
  logic wr_req, rd_req;

  cfg_par_ctrl u_ctrl (
    .clk_i, .rst_ni, .cs_ni, .rdwr_i, .persist_i, .done_i,
    .wr_req_o(wr_req), .rd_req_o(rd_req),
    .abort_o, .user_mode_o
  );

  cfg_par_wr #(.W(W)) u_wr (
    .clk_i, .rst_ni, .req_i(wr_req), .pins_i(bus_i),
    .byte_o(wr_byte_o), .valid_o(wr_valid_o)
  );

  cfg_par_rd #(.W(W)) u_rd (
    .clk_i, .rst_ni, .req_i(rd_req),
    .src_data_i(rb_data_i), .src_empty_i(rb_empty_i),
    .pop_o(rb_pop_o), .pins_o(bus_o), .oe_o(bus_oe_o), .underflow_o
  );

  assert_oe_only_after_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> $past(!cs_ni && rdwr_i && persist_i));
  assert_pop_needs_persist_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_pop_o |-> (persist_i && !cs_ni && rdwr_i));
  assert_no_write_when_deselected_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(!cs_ni && !rdwr_i));
endmodule

// File: tb/tb_cfg_par_port.sv
module tb_cfg_par_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cs_n = 1, rdwr = 0, persist = 0, done = 0;
  logic [7:0] pins = 0, rb_data = 0;
  logic rb_empty = 1;
  logic [7:0] bus_o, wr_byte;
  logic bus_oe, wr_valid, rb_pop, abort_f, uflow, user_m;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] src_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_par_port dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rdwr_i(rdwr), .bus_i(pins),
    .bus_o(bus_o), .bus_oe_o(bus_oe), .persist_i(persist), .done_i(done),
    .wr_byte_o(wr_byte), .wr_valid_o(wr_valid), .rb_data_i(rb_data),
    .rb_empty_i(rb_empty), .rb_pop_o(rb_pop), .abort_o(abort_f),
    .underflow_o(uflow), .user_mode_o(user_m)
  );

  function automatic logic [7:0] rev(input logic [7:0] v);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[7-k] = v[k];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic refresh();
    rb_empty = (src_q.size() == 0);
    rb_data  = (src_q.size() != 0) ? src_q[0] : 8'h00;
  endtask

  // scoreboard monitor for the sink side
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected wr_valid", wr_byte, 8'h00);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(wr_byte == e, "R3 write byte", wr_byte, e);
      end
    end
  end

  task automatic do_reset(input logic p);
    @(negedge clk);
    rst_n = 0; cs_n = 1; rdwr = 0; done = 0; persist = p;
    exp_q.delete(); src_q.delete(); refresh();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b, input bit accept);
    @(negedge clk);
    cs_n = 0; rdwr = 0; pins = rev(b);
    if (accept) exp_q.push_back(b);
    @(negedge clk);
    cs_n = 1;
    chk(bus_oe == 0, "R6 no drive after write", {7'd0, bus_oe}, 8'h00);
    if (!accept) chk(wr_valid == 0, "R9/R7 write ignored", {7'd0, wr_valid}, 8'h00);
  endtask

  task automatic rd(input bit expect_pop);
    logic [7:0] e;
    @(negedge clk);
    cs_n = 0; rdwr = 1;
    #1;
    chk(rb_pop == expect_pop, "R4/R5 pop strobe", {7'd0, rb_pop}, {7'd0, expect_pop});
    e = rb_data;
    @(negedge clk);
    cs_n = 1; rdwr = 0;
    if (expect_pop) begin
      chk(bus_oe == 1, "R4 bus driven", {7'd0, bus_oe}, 8'h01);
      chk(rev(bus_o) == e, "R4 readback byte pin-reversed", rev(bus_o), e);
      void'(src_q.pop_front());
      refresh();
    end else begin
      chk(bus_oe == 0, "R5/R9 read ignored", {7'd0, bus_oe}, 8'h00);
    end
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    chk(0, "watchdog expired", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    // session A: persist off
    do_reset(0);
    chk({wr_valid, bus_oe, rb_pop, abort_f, uflow, user_m} == 6'd0, "R1 reset state",
        {2'd0, wr_valid, bus_oe, rb_pop, abort_f, uflow, user_m}, 8'h00);

    @(negedge clk); cs_n = 1; rdwr = 1; pins = 8'hFF; src_q.push_back(8'h77); refresh();
    #1 chk(rb_pop == 0, "R2 no pop deselected", {7'd0, rb_pop}, 8'h00);
    repeat (3) @(negedge clk);
    chk(abort_f == 0 && bus_oe == 0, "R2 deselected ignored", {6'd0, abort_f, bus_oe}, 8'h00);
    rdwr = 0;

    rd(0);
    chk(src_q.size() == 1, "R5 source untouched", 8'(src_q.size()), 8'h01);
    chk(abort_f == 0, "R7 read before write no error", {7'd0, abort_f}, 8'h00);

    wr(8'hA5, 1); wr(8'h01, 1); wr(8'h80, 1); wr(8'h3C, 1);

    @(negedge clk); cs_n = 0; rdwr = 1;
    #1 chk(rb_pop == 0, "R7 no read on error edge", {7'd0, rb_pop}, 8'h00);
    @(negedge clk); cs_n = 1; rdwr = 0;
    chk(abort_f == 1, "R7 abort set", {7'd0, abort_f}, 8'h01);
    wr(8'h11, 0);
    pulse_done();
    chk(abort_f == 1 && user_m == 0, "R7 abort sticky", {6'd0, abort_f, user_m}, 8'h02);

    // session B: persist on
    do_reset(1);
    src_q.push_back(8'h12); src_q.push_back(8'hC3); refresh();
    rd(1); rd(1);
    @(negedge clk); cs_n = 0; rdwr = 1;
    #1 chk(rb_pop == 0, "R11 no pop on empty", {7'd0, rb_pop}, 8'h00);
    @(negedge clk); cs_n = 1; rdwr = 0;
    chk(uflow == 1, "R11 underflow set", {7'd0, uflow}, 8'h01);
    chk(bus_oe == 1 && rev(bus_o) == 8'hC3, "R11 bus holds last byte", rev(bus_o), 8'hC3);

    wr(8'h5A, 1);
    pulse_done();
    chk(user_m == 1, "R8 user mode after done", {7'd0, user_m}, 8'h01);
    wr(8'hE7, 1);
    src_q.push_back(8'h9D); refresh();
    rd(1);
    chk(abort_f == 0, "R10 read after write in user mode", {7'd0, abort_f}, 8'h00);
    chk(uflow == 1, "R11 underflow still set", {7'd0, uflow}, 8'h01);

    // session C: persist off, user mode
    do_reset(0);
    wr(8'h44, 1);
    pulse_done();
    chk(user_m == 1, "R8 user mode", {7'd0, user_m}, 8'h01);
    wr(8'h99, 0);
    src_q.push_back(8'h21); refresh();
    rd(0);
    chk(src_q.size() == 1, "R9 source untouched", 8'(src_q.size()), 8'h01);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected writes seen", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule